// File: doc/BRIEF.md
# Soft Mute Gain Ramp for Stereo Output Samples

This block sits on the output side of a stereo sample path. It scales each left/right pair by a gain that moves by one step per accepted output sample. When a mute request is raised, the gain falls from unity to silence over 1024 samples. When the request is dropped, the gain climbs back over the same number of samples. If the request changes while the gain is moving, the ramp turns around from where it stands. The gain is an 11-bit count `g` in the range 0 to 1024, and each sample is multiplied by `g/1024` with the fraction discarded (floor).

A second mode, power-up hold, is meant for start-up. After reset is released, the output is held silent for 4410 samples. After that, the block follows the mute request: it ramps up on its own if the request is low, or stays silent if the request is high. An active-low reset and a loss-of-lock flag both force the output data to zero.

Samples enter and leave on valid/ready streams. The block holds one registered stage, so an accepted pair appears on the output one clock later. `s_ready` is high whenever the output register is empty or is being drained in the same cycle. While `m_valid` is high and `m_ready` is low, the output pair holds still and no new input is taken. The gain moves only when an input pair is accepted.

After scaling, the word is cut to a selected output width. The result can then carry an optional +1 LSB pseudo-random dither at that width, which saturates at positive full scale.

Top module: `soft_mute_ramp`

## Requirements
- R1: With `hold_mode`=0 the gain is 1024 out of reset. While `mute_req`=1, each accepted pair uses the current gain and then lowers it by one, down to 0. The output is floor(sample*g/1024), so full silence is reached on the 1025th pair after the request rises.
- R2: While `mute_req`=0, each accepted pair uses the current gain and then raises it by one, up to 1024 where it stays.
- R3: If `mute_req` falls while the gain is between the ends of its range, the next pair uses the level already reached, and the gain then rises one step per pair from there.
- R4: With `hold_mode`=1, the first 4410 pairs accepted after reset release give zero output. Pair 4410+j then uses gain min(j,1024) while `mute_req`=0.
- R5: With `hold_mode`=1 and `mute_req`=1 at reset release, the output stays zero after the hold ends for as long as the request stays high.
- R6: While `rst_n`=0, `m_valid`, `m_left` and `m_right` are 0. A pair accepted while `pll_unlock`=1 is output as zeros with `m_valid`=1.
- R7: `width_sel` picks the output width: 0 gives 16 bits, 1 gives 18, 2 gives 20 and 3 gives 24. The result is left-aligned in the 24-bit word, with the bits below the chosen width cleared (the lower bits are discarded, so the value rounds down).
- R8: With `dither_en`=1, each channel's word is either the undithered word or that word plus one LSB of the chosen width. It never wraps past positive full scale, and both values occur over a run of pairs.
- R9: `s_ready` = !`m_valid` || `m_ready`. While `m_valid`=1 and `m_ready`=0, the output data holds still, and no pair is accepted, so the gain does not step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset / power-down |
| mute_req | input | 1 | Mute request (1 = ramp to silence) |
| hold_mode | input | 1 | 0 = manual, 1 = power-up hold then follow request |
| pll_unlock | input | 1 | Loss of lock; forces output data to zero |
| dither_en | input | 1 | Enables +1 LSB pseudo-random dither |
| width_sel | input | 2 | Output width code (0:16, 1:18, 2:20, 3:24 bits) |
| s_valid | input | 1 | Input pair valid |
| s_ready | output | 1 | Block can accept a pair |
| s_left | input | 24 | Left input sample, two's complement |
| s_right | input | 24 | Right input sample, two's complement |
| m_valid | output | 1 | Output pair valid |
| m_ready | input | 1 | Downstream accepts the output pair |
| m_left | output | 24 | Left scaled sample |
| m_right | output | 24 | Right scaled sample |

## Verification
On every cycle, the assertions check several properties:
- The gain never leaves 0 to 1024 and moves by at most one per cycle.
- The gain does not move without an accepted pair.
- A stalled output holds still.
- Pairs taken during loss of lock come out as zero.
- The cleared low bits stay clear.
- Dither never wraps a positive word negative.

Only the bench's scenarios show the values that depend on long histories:
- the exact gain sequence of a full ramp down and up;
- the turnaround level;
- the 4410-pair hold and the start of its ramp;
- the stay-silent case;
- the width truncation table;
- the fact that dither really takes both values.

// File: rtl/smr_pkg.sv
package smr_pkg;
  typedef enum logic [1:0] {
    WID_16 = 2'd0,
    WID_18 = 2'd1,
    WID_20 = 2'd2,
    WID_24 = 2'd3
  } width_code_e;

  function automatic int unsigned cleared_bits(input logic [1:0] code, input int unsigned dw);
    case (width_code_e'(code))
      WID_16:  return dw - 16;
      WID_18:  return dw - 18;
      WID_20:  return dw - 20;
      default: return dw - 24;
    endcase
  endfunction
endpackage

// File: rtl/smr_gain_ctrl.sv
module smr_gain_ctrl #(
  parameter int RAMP_LOG2 = 10,
  parameter int HOLD_LEN  = 4410,
  localparam int GW = RAMP_LOG2 + 1,
  localparam int HW = $clog2(HOLD_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          mute_req,
  input  logic          hold_mode,
  output logic [GW-1:0] gain_o
);
  localparam logic [GW-1:0] UNITY = {1'b1, {RAMP_LOG2{1'b0}}};

  logic [GW-1:0] gain_q;
  logic [HW-1:0] hold_q;
  logic          holding;

  assign holding = hold_mode && (hold_q != '0);
  assign gain_o  = holding ? '0 : gain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q <= UNITY;
      hold_q <= HW'(HOLD_LEN);
    end else begin
      if (step && hold_q != '0) hold_q <= hold_q - 1'b1;
      if (holding) begin
        gain_q <= '0;
      end else if (step) begin
        if (mute_req && gain_q != '0)         gain_q <= gain_q - 1'b1;
        else if (!mute_req && gain_q != UNITY) gain_q <= gain_q + 1'b1;
      end
    end
  end

  assert_gain_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    gain_q <= UNITY);

  assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!holding && !$past(holding)) |->
      (gain_q == $past(gain_q) || gain_q == $past(gain_q) + 1'b1 || gain_q + 1'b1 == $past(gain_q)));

  assert_no_move_unaccepted_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !holding) |=> $stable(gain_q));
endmodule

// File: rtl/smr_lfsr.sv
module smr_lfsr #(
  parameter int            LW   = 16,
  parameter logic [LW-1:0] TAPS = 16'hB400,
  parameter logic [LW-1:0] SEED = 16'hACE1,
  parameter int            NOUT = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  output logic [NOUT-1:0] rnd
);
  logic [LW-1:0] st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   st_q <= SEED;
    else if (adv) st_q <= st_q[0] ? ((st_q >> 1) ^ TAPS) : (st_q >> 1);
  end

  assign rnd = st_q[NOUT-1:0];

  assert_lfsr_alive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    st_q != '0);
endmodule

// File: rtl/smr_lane.sv
module smr_lane
  import smr_pkg::*;
#(
  parameter int DW = 24,
  parameter int RAMP_LOG2 = 10,
  localparam int GW = RAMP_LOG2 + 1,
  localparam int PW = DW + GW + 1
) (
  input  logic [DW-1:0] sample,
  input  logic [GW-1:0] gain,
  input  logic [1:0]    width_sel,
  input  logic          dith_on,
  output logic [DW-1:0] result
);
  logic signed [PW-1:0] prod;
  logic [DW-1:0] scaled, lsb, keep_mask, trunc, sum;
  logic          wrap;

  always_comb begin
    prod      = $signed(sample) * $signed({1'b0, gain});
    scaled    = prod[RAMP_LOG2 +: DW];
    lsb       = DW'(1) << cleared_bits(width_sel, DW);
    keep_mask = ~(lsb - 1'b1);
    trunc     = scaled & keep_mask;
    sum       = trunc + (dith_on ? lsb : '0);
    wrap      = !trunc[DW-1] && sum[DW-1];
    result    = wrap ? trunc : sum;
  end

  always_comb begin
    assert_prod_fits_R1: assert (prod[PW-1:RAMP_LOG2+DW-1] == '0 || &prod[PW-1:RAMP_LOG2+DW-1]);
    assert_low_bits_clear_R7: assert ((result & (lsb - 1'b1)) == '0);
    assert_no_wrap_R8: assert (!(!scaled[DW-1] && result[DW-1]));
  end

  logic unused_low;
  assign unused_low = ^prod[RAMP_LOG2-1:0];
endmodule

// File: rtl/soft_mute_ramp.sv
module soft_mute_ramp #(
  parameter int DW        = 24,
  parameter int RAMP_LOG2 = 10,
  parameter int HOLD_LEN  = 4410,
  localparam int NCH = 2,
  localparam int GW  = RAMP_LOG2 + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mute_req,
  input  logic          hold_mode,
  input  logic          pll_unlock,
  input  logic          dither_en,
  input  logic [1:0]    width_sel,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_left,
  input  logic [DW-1:0] s_right,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [DW-1:0] m_left,
  output logic [DW-1:0] m_right
);
  logic          acc;
  logic [GW-1:0] gain;
  logic [NCH-1:0] rnd;
  logic [DW-1:0] lane_in  [NCH];
  logic [DW-1:0] lane_out [NCH];

  assign s_ready    = !m_valid || m_ready;
  assign acc        = s_valid && s_ready;
  assign lane_in[0] = s_left;
  assign lane_in[1] = s_right;

  smr_gain_ctrl #(.RAMP_LOG2(RAMP_LOG2), .HOLD_LEN(HOLD_LEN)) u_gain (
    .clk(clk), .rst_n(rst_n), .step(acc), .mute_req(mute_req),
    .hold_mode(hold_mode), .gain_o(gain)
  );

  smr_lfsr #(.NOUT(NCH)) u_rnd (
    .clk(clk), .rst_n(rst_n), .adv(acc), .rnd(rnd)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    smr_lane #(.DW(DW), .RAMP_LOG2(RAMP_LOG2)) u_lane (
      .sample(lane_in[c]), .gain(gain), .width_sel(width_sel),
      .dith_on(dither_en && rnd[c]), .result(lane_out[c])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_left  <= '0;
      m_right <= '0;
    end else if (acc) begin
      m_valid <= 1'b1;
      m_left  <= pll_unlock ? '0 : lane_out[0];
      m_right <= pll_unlock ? '0 : lane_out[1];
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

  assert_unlock_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && pll_unlock) |=> (m_valid && m_left == '0 && m_right == '0));

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_left) && $stable(m_right)));
endmodule

// File: tb/sim_soft_mute_ramp.sv
`timescale 1ns/1ps
module sim_soft_mute_ramp;
  logic clk = 0, rst_n = 0, mute_req = 0, hold_mode = 0, pll_unlock = 0, dither_en = 0;
  logic [1:0] width_sel = 2'd3;
  logic s_valid = 0, m_ready = 1, s_ready, m_valid;
  logic [23:0] s_left = 0, s_right = 0, m_left, m_right;
  logic [23:0] got_l, got_r;
  logic got_v;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  soft_mute_ramp u0 (
    .clk(clk), .rst_n(rst_n), .mute_req(mute_req), .hold_mode(hold_mode),
    .pll_unlock(pll_unlock), .dither_en(dither_en), .width_sel(width_sel),
    .s_valid(s_valid), .s_ready(s_ready), .s_left(s_left), .s_right(s_right),
    .m_valid(m_valid), .m_ready(m_ready), .m_left(m_left), .m_right(m_right)
  );

  typedef struct packed {
    logic [1:0]  w;
    logic [23:0] l, r, el, er;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'd0, 24'h123456, 24'hEDCBA9, 24'h123400, 24'hEDCB00},
    '{2'd1, 24'h123456, 24'h800001, 24'h123440, 24'h800000},
    '{2'd2, 24'h123456, 24'hFFFFFF, 24'h123450, 24'hFFFFF0},
    '{2'd3, 24'h123456, 24'h000001, 24'h123456, 24'h000001},
    '{2'd0, 24'h7FFFFF, 24'h800000, 24'h7FFF00, 24'h800000},
    '{2'd1, 24'h00003F, 24'h0000C1, 24'h000000, 24'h0000C0},
    '{2'd2, 24'hABCDEF, 24'h00000F, 24'hABCDE0, 24'h000000},
    '{2'd3, 24'h7FFFFF, 24'h800000, 24'h7FFFFF, 24'h800000}
  };

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [23:0] l, input logic [23:0] r);
    @(negedge clk);
    s_valid = 1; s_left = l; s_right = r;
    @(posedge clk); #1;
    got_l = m_left; got_r = m_right; got_v = m_valid;
  endtask

  task automatic idle();
    @(negedge clk);
    s_valid = 0;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; s_valid = 0;
    @(negedge clk);
    rst_n = 1;
  endtask

  function automatic logic [23:0] ramp_val(input int g);
    return 24'(4096 * g);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit seen0, seen1;
    // R6: reset state
    @(negedge clk);
    s_valid = 1; s_left = 24'h123456;
    @(posedge clk); #1;
    chk("R6 valid in reset", {23'd0, m_valid}, 24'd0);
    chk("R6 left in reset", m_left, 24'd0);
    chk("R9 ready in reset", {23'd0, s_ready}, 24'd1);
    @(negedge clk); s_valid = 0; rst_n = 1;

    // R7: vector table at unity gain
    foreach (VECS[i]) begin
      width_sel = VECS[i].w;
      xfer(VECS[i].l, VECS[i].r);
      chk("R7 left", got_l, VECS[i].el);
      chk("R7 right", got_r, VECS[i].er);
      chk("R9 valid", {23'd0, got_v}, 24'd1);
    end
    width_sel = 2'd3;

    // R1: ramp down
    mute_req = 1;
    for (int k = 0; k < 1030; k++) begin
      xfer(24'h400000, 24'h400000);
      chk("R1 ramp down", got_l, ramp_val(k < 1024 ? 1024 - k : 0));
    end
    // R2: ramp up
    mute_req = 0;
    for (int k = 0; k < 1030; k++) begin
      xfer(24'h400000, 24'h400000);
      chk("R2 ramp up", got_r, ramp_val(k < 1024 ? k : 1024));
    end
    // R3: reversal mid-ramp
    mute_req = 1;
    for (int k = 0; k < 300; k++) xfer(24'h400000, 24'h400000);
    chk("R3 before turn", got_l, ramp_val(725));
    mute_req = 0;
    for (int j = 0; j < 310; j++) begin
      xfer(24'h400000, 24'h400000);
      chk("R3 turnaround", got_l, ramp_val(724 + j > 1024 ? 1024 : 724 + j));
    end

    // R9: back-pressure
    xfer(24'h222222, 24'h333333);
    @(negedge clk);
    m_ready = 0; s_left = 24'h111111; s_right = 24'h111111;
    #1;
    chk("R9 ready low on stall", {23'd0, s_ready}, 24'd0);
    @(posedge clk); #1;
    chk("R9 stall hold", m_left, 24'h222222);
    @(negedge clk); m_ready = 1;
    @(posedge clk); #1;
    chk("R9 after release", m_left, 24'h111111);
    idle();
    chk("R9 drained", {23'd0, m_valid}, 24'd0);

    // R6: loss of lock
    pll_unlock = 1;
    xfer(24'h123456, 24'h654321);
    chk("R6 unlock left", got_l, 24'd0);
    chk("R6 unlock valid", {23'd0, got_v}, 24'd1);
    pll_unlock = 0;
    xfer(24'h123456, 24'h654321);
    chk("R6 relock", got_l, 24'h123456);

    // R8: dither
    dither_en = 1; width_sel = 2'd0; seen0 = 0; seen1 = 0;
    for (int k = 0; k < 64; k++) begin
      xfer(24'h123456, 24'h7FFFFF);
      if (got_l == 24'h123400) seen0 = 1;
      else if (got_l == 24'h123500) seen1 = 1;
      else chk("R8 dither value", got_l, 24'h123400);
      chk("R8 saturate", got_r, 24'h7FFF00);
    end
    chk("R8 both values", {22'd0, seen1, seen0}, 24'd3);
    width_sel = 2'd3;
    xfer(24'h7FFFFF, 24'h7FFFFF);
    chk("R8 saturate 24", got_l, 24'h7FFFFF);
    dither_en = 0;

    // R6: reset mid-stream
    @(negedge clk); rst_n = 0;
    @(posedge clk); #1;
    chk("R6 reset clears valid", {23'd0, m_valid}, 24'd0);
    chk("R6 reset clears data", m_right, 24'd0);
    @(negedge clk); s_valid = 0; rst_n = 1;

    // R4: power-up hold
    hold_mode = 1; mute_req = 0;
    do_reset();
    for (int k = 0; k < 4410 + 1030; k++) begin
      xfer(24'h400000, 24'h400000);
      if (k < 4410) chk("R4 hold silent", got_l, 24'd0);
      else chk("R4 hold ramp", got_l, ramp_val(k - 4410 > 1024 ? 1024 : k - 4410));
    end

    // R5: request high at release
    mute_req = 1;
    do_reset();
    for (int k = 0; k < 5500; k++) begin
      xfer(24'h400000, 24'h400000);
      chk("R5 stays muted", got_r, 24'd0);
    end
    mute_req = 0;
    xfer(24'h400000, 24'h400000);
    chk("R5 release start", got_l, 24'd0);
    xfer(24'h400000, 24'h400000);
    chk("R5 release step", got_l, ramp_val(1));
    idle();

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule